// File: doc/BRIEF.md
# Stack-Top Register Cache

This block keeps the topmost words of a stack that lives in memory inside a small multiported store, so that instruction operands can name "registers" as offsets from the stack pointer instead of as fixed cells. Each access can use two read ports and one write port. Each port names either a stack slot, by its distance below the top of stack, or one of a few global registers that lie outside the stack mapping.

The stack grows toward higher addresses. The pointer holds the number of words in use, so offset k names stack address `sp - 1 - k`. Slot storage is indexed by the stack address modulo the cache depth, which means a pointer adjust never moves data. A single adjust command can reserve or release many words at once. Reserved words are ready at once with no memory read, because their old contents are garbage. Released words are dropped with no write-back, even when dirty. The adjust checks the new pointer against a limit register and raises a trap instead of committing when the pointer would pass it.

An access whose stack address is not held in its slot stalls. The block writes the occupant back to memory if it is dirty, then reads the wanted word, then completes the access. It skips the read when the wanted word was reserved by an adjust while the slot was still busy with older dirty data. Memory is reached through a simple request/acknowledge port.

Top module: `stk_regcache`

## Requirements
- R1: After reset the stack pointer is 0, the limit is all ones, trap is 0, no memory request is raised and stall is low while no access is presented.
- R2: A stack operand with offset k on either read port returns the word last written to stack address `sp - 1 - k`. Both read ports serve different offsets in the same access.
- R3: An adjust with a positive delta commits `sp + delta` and leaves the newly covered words usable with no memory read. Writes and reads to them then complete without a stall.
- R4: An adjust with a negative delta commits `sp + delta` and discards the uncovered words with no memory write, even when they were dirty.
- R5: An adjust whose result, computed with one extra bit, is negative or exceeds the limit unsigned does not move the pointer and sets trap to 1 for one cycle in the cycle after the command. A result equal to the limit commits with no trap.
- R6: Global registers are selected by the glob flag of a port, with the index in the low bits of the offset. They are never affected by pointer adjusts and never miss.
- R7: An access to a stack address not held in its slot stalls. The block writes back the slot's old word if it is dirty, reads the wanted word from memory, then completes with the memory value.
- R8: When the write port and a read port name the same stack address or the same global register in one access, the read returns the data being written.
- R9: An adjust presented during a stalled access is held until the access completes, and then takes effect after that access, which uses the old pointer.
- R10: A zero delta, or cycles with no access and no adjust, change neither the pointer nor any stored word, and cause no memory traffic.
- R11: When a growing adjust covers a slot that still holds a dirty older word, that older word stays readable. The first access to the new word writes the older word back and takes the slot without a memory read.
- R12: Asserting the limit-load input stores a new limit value, which later adjusts check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented; held until stall is low |
| rda_en | input | 1 | Read port A in use |
| rda_glob | input | 1 | Port A selects a global register |
| rda_off | input | OW | Port A stack offset or global index |
| rda_data | output | DW | Port A read data |
| rdb_en | input | 1 | Read port B in use |
| rdb_glob | input | 1 | Port B selects a global register |
| rdb_off | input | OW | Port B stack offset or global index |
| rdb_data | output | DW | Port B read data |
| wr_en | input | 1 | Write port in use |
| wr_glob | input | 1 | Write targets a global register |
| wr_off | input | OW | Write stack offset or global index |
| wr_data | input | DW | Write data |
| stall | output | 1 | Access cannot complete this cycle |
| adj_valid | input | 1 | Stack pointer adjust command |
| adj_delta | input | AW | Signed pointer delta |
| lim_we | input | 1 | Load the limit register |
| lim_din | input | AW | New limit value |
| sp_out | output | AW | Current stack pointer |
| trap | output | 1 | Adjust refused by the limit check (one-cycle pulse) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write-back data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
The stack mapping is swept with every pointer depth from one to the cache depth. The sweep writes stack-derived values and reads them back in pairs through both ports, which separates a wrong offset-to-address sign or origin from a wrong slot index. Shrinking and regrowing over dirty words is done while the memory request counters are watched, which tells a lazy reserve or discard apart from a hidden spill or fill. A grow of exactly the cache depth over a fully dirty cache, followed by accesses to old and new addresses, drives the write-back path both with and without a fill. Adjusts one past the limit, at the limit, below zero and zero-sized mark the trap boundary, and one adjust is issued during a stalled access to show its ordering.

// File: rtl/stk_regcache.sv
module stk_regcache #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  parameter int OW    = 4,
  parameter int NGLOB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          rda_en,
  input  logic          rda_glob,
  input  logic [OW-1:0] rda_off,
  output logic [DW-1:0] rda_data,
  input  logic          rdb_en,
  input  logic          rdb_glob,
  input  logic [OW-1:0] rdb_off,
  output logic [DW-1:0] rdb_data,
  input  logic          wr_en,
  input  logic          wr_glob,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  output logic          stall,
  input  logic          adj_valid,
  input  logic [AW-1:0] adj_delta,
  input  logic          lim_we,
  input  logic [AW-1:0] lim_din,
  output logic [AW-1:0] sp_out,
  output logic          trap,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW  = $clog2(DEPTH);
  localparam int GIW = $clog2(NGLOB);

  typedef enum logic [1:0] {IDLE, SPILL, FILL} st_t;
  st_t st;

  logic [AW-1:0]    sp, lim;
  logic [DEPTH-1:0] vld, drt, nof;
  logic [AW-1:0]    tag  [DEPTH];
  logic [AW-1:0]    ntag [DEPTH];
  logic [DW-1:0]    sdat [DEPTH];
  logic [DW-1:0]    greg [NGLOB];
  logic [IW-1:0]    mslot;
  logic [AW-1:0]    maddr;
  logic             trap_q;

  logic [AW-1:0] a_a, a_b, a_w;
  logic [IW-1:0] s_a, s_b, s_w;
  assign a_a = sp - AW'(1) - AW'(rda_off);
  assign a_b = sp - AW'(1) - AW'(rdb_off);
  assign a_w = sp - AW'(1) - AW'(wr_off);
  assign s_a = a_a[IW-1:0];
  assign s_b = a_b[IW-1:0];
  assign s_w = a_w[IW-1:0];

  logic hit_a, hit_b, hit_w, m_a, m_b, m_w, miss;
  assign hit_a = vld[s_a] && tag[s_a] == a_a;
  assign hit_b = vld[s_b] && tag[s_b] == a_b;
  assign hit_w = vld[s_w] && tag[s_w] == a_w;
  assign m_a   = rda_en && !rda_glob && !hit_a;
  assign m_b   = rdb_en && !rdb_glob && !hit_b;
  assign m_w   = wr_en && !wr_glob && !hit_w;
  assign miss  = m_a || m_b || m_w;

  logic [AW-1:0] m_addr;
  logic [IW-1:0] ms;
  assign m_addr = m_a ? a_a : (m_b ? a_b : a_w);
  assign ms     = m_addr[IW-1:0];

  logic go, wcommit, gcommit;
  assign stall   = acc_valid && (miss || st != IDLE);
  assign go      = acc_valid && !miss && st == IDLE;
  assign wcommit = go && wr_en && !wr_glob;
  assign gcommit = go && wr_en && wr_glob;

  logic byp_a, byp_b;
  assign byp_a = acc_valid && wr_en && (wr_glob == rda_glob) &&
                 (wr_glob ? wr_off[GIW-1:0] == rda_off[GIW-1:0] : a_w == a_a);
  assign byp_b = acc_valid && wr_en && (wr_glob == rdb_glob) &&
                 (wr_glob ? wr_off[GIW-1:0] == rdb_off[GIW-1:0] : a_w == a_b);
  assign rda_data = byp_a ? wr_data : (rda_glob ? greg[rda_off[GIW-1:0]] : sdat[s_a]);
  assign rdb_data = byp_b ? wr_data : (rdb_glob ? greg[rdb_off[GIW-1:0]] : sdat[s_b]);

  logic          adj_go, over, grow, shrink, commit_adj;
  logic [AW:0]   nsp_x;
  logic [AW-1:0] nsp, top;
  assign adj_go     = adj_valid && !stall && st == IDLE;
  assign nsp_x      = {1'b0, sp} + {adj_delta[AW-1], adj_delta};
  assign over       = nsp_x > {1'b0, lim};
  assign nsp        = nsp_x[AW-1:0];
  assign top        = nsp - AW'(1);
  assign grow       = !adj_delta[AW-1] && (adj_delta != '0);
  assign shrink     = adj_delta[AW-1];
  assign commit_adj = adj_go && !over;

  logic [DEPTH-1:0] cov, kill, nkill, stale, wsel, drt_eff;
  logic [AW-1:0]    cand [DEPTH];
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [AW:0] c0, c1;
    assign c0          = {1'b0, top[AW-1:IW], IW'(gi)};
    assign c1          = (c0 > {1'b0, top}) ? c0 - (AW+1)'(DEPTH) : c0;
    assign cand[gi]    = c1[AW-1:0];
    assign cov[gi]     = grow && (c1 <= {1'b0, top}) && (c1 >= {1'b0, sp});
    assign kill[gi]    = shrink && vld[gi] && tag[gi] >= nsp && tag[gi] < sp;
    assign nkill[gi]   = shrink && nof[gi] && ntag[gi] >= nsp && ntag[gi] < sp;
    assign stale[gi]   = vld[gi] && tag[gi] >= sp;
    assign wsel[gi]    = wcommit && (s_w == IW'(gi));
    assign drt_eff[gi] = vld[gi] && (drt[gi] || wsel[gi]);
  end

  logic idle_take, idle_dirty, idle_alloc, spill_done, spill_alloc, fill_done;
  assign idle_take   = st == IDLE && acc_valid && miss;
  assign idle_dirty  = vld[ms] && drt[ms];
  assign idle_alloc  = idle_take && !idle_dirty && nof[ms] && ntag[ms] == m_addr;
  assign spill_done  = st == SPILL && mem_ack;
  assign spill_alloc = spill_done && nof[mslot] && ntag[mslot] == maddr;
  assign fill_done   = st == FILL && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      sp     <= '0;
      lim    <= '1;
      vld    <= '0;
      drt    <= '0;
      nof    <= '0;
      mslot  <= '0;
      maddr  <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= adj_go && over;
      if (lim_we) lim <= lim_din;
      case (st)
        IDLE: if (idle_take) begin
          mslot <= ms;
          maddr <= m_addr;
          if (idle_dirty) st <= SPILL;
          else if (idle_alloc) begin
            vld[ms] <= 1'b1;
            drt[ms] <= 1'b0;
            nof[ms] <= 1'b0;
          end else st <= FILL;
        end
        SPILL: if (spill_done) begin
          drt[mslot] <= 1'b0;
          if (spill_alloc) begin
            vld[mslot] <= 1'b1;
            nof[mslot] <= 1'b0;
            st         <= IDLE;
          end else begin
            vld[mslot] <= 1'b0;
            st         <= FILL;
          end
        end
        FILL: if (fill_done) begin
          vld[mslot] <= 1'b1;
          drt[mslot] <= 1'b0;
          st         <= IDLE;
        end
        default: st <= IDLE;
      endcase
      if (wcommit) drt[s_w] <= 1'b1;
      if (commit_adj) begin
        sp <= nsp;
        for (int i = 0; i < DEPTH; i++) begin
          if (cov[i]) begin
            if (drt_eff[i]) nof[i] <= 1'b1;
            else begin
              vld[i] <= 1'b1;
              drt[i] <= 1'b0;
              nof[i] <= 1'b0;
            end
          end
          if (kill[i]) begin
            vld[i] <= 1'b0;
            drt[i] <= 1'b0;
          end
          if (nkill[i]) nof[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wcommit)   sdat[s_w] <= wr_data;
    if (fill_done) sdat[mslot] <= mem_rdata;
    if (gcommit)   greg[wr_off[GIW-1:0]] <= wr_data;
    if (idle_alloc) tag[ms] <= m_addr;
    if (spill_alloc || fill_done) tag[mslot] <= maddr;
    if (commit_adj)
      for (int i = 0; i < DEPTH; i++)
        if (cov[i]) begin
          if (drt_eff[i]) ntag[i] <= cand[i];
          else            tag[i]  <= cand[i];
        end
  end

  assign sp_out    = sp;
  assign trap      = trap_q;
  assign mem_req   = st != IDLE;
  assign mem_we    = st == SPILL;
  assign mem_addr  = (st == SPILL) ? tag[mslot] : maddr;
  assign mem_wdata = sdat[mslot];

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> sp == $past(sp)); // R5
  AST_SP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> sp <= $past(lim)); // R5
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(sp)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(acc_valid && stall)); // R3
  AST_SHRINK_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_adj && shrink) |=> (stale == '0)); // R4
endmodule

// File: tb/stk_regcache_tb_top.sv
module stk_regcache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        acc_valid = 0, rda_en = 0, rda_glob = 0, rdb_en = 0, rdb_glob = 0;
  logic        wr_en = 0, wr_glob = 0, adj_valid = 0, lim_we = 0, mem_ack = 0;
  logic [3:0]  rda_off = 0, rdb_off = 0, wr_off = 0;
  logic [15:0] wr_data = 0, mem_rdata = 0;
  logic [7:0]  adj_delta = 0, lim_din = 0;
  logic [15:0] rda_data, rdb_data, mem_wdata;
  logic [7:0]  sp_out, mem_addr;
  logic        stall, trap, mem_req, mem_we;

  stk_regcache dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .rda_en(rda_en), .rda_glob(rda_glob), .rda_off(rda_off), .rda_data(rda_data),
    .rdb_en(rdb_en), .rdb_glob(rdb_glob), .rdb_off(rdb_off), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_glob(wr_glob), .wr_off(wr_off), .wr_data(wr_data),
    .stall(stall), .adj_valid(adj_valid), .adj_delta(adj_delta),
    .lim_we(lim_we), .lim_din(lim_din), .sp_out(sp_out), .trap(trap),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem [256];
  logic [15:0] expv [256];
  int nrd = 0, nwr = 0, lat = 0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      lat = 0;
    end else if (mem_req) begin
      lat++;
      if (lat == 2) begin
        mem_ack = 1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          nwr++;
        end else begin
          mem_rdata = mem[mem_addr];
          nrd++;
        end
      end
    end else lat = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic ea, input logic ga, input logic [3:0] oa,
                     input logic eb, input logic gb, input logic [3:0] ob,
                     input logic we, input logic wg, input logic [3:0] ow,
                     input logic [15:0] wd, output logic [15:0] da, output logic [15:0] db);
    acc_valid = 1; rda_en = ea; rda_glob = ga; rda_off = oa;
    rdb_en = eb; rdb_glob = gb; rdb_off = ob;
    wr_en = we; wr_glob = wg; wr_off = ow; wr_data = wd;
    #1;
    while (stall) begin
      @(negedge clk);
      #1;
    end
    da = rda_data;
    db = rdb_data;
    @(negedge clk);
    acc_valid = 0; rda_en = 0; rdb_en = 0; wr_en = 0;
  endtask

  function automatic logic [3:0] off_of(input int a);
    return 4'(int'(sp_out) - 1 - a);
  endfunction

  task automatic wr_a(input int a, input logic [15:0] v);
    logic [15:0] d0, d1;
    acc(0, 0, 0, 0, 0, 0, 1, 0, off_of(a), v, d0, d1);
    expv[a] = v;
  endtask

  task automatic rd_a(input string req, input int a);
    logic [15:0] d0, d1;
    acc(1, 0, off_of(a), 0, 0, 0, 0, 0, 0, 0, d0, d1);
    chk(req, d0, expv[a]);
  endtask

  task automatic adjust(input int d, output logic t);
    adj_valid = 1;
    adj_delta = 8'(d);
    @(negedge clk);
    adj_valid = 0;
    t = trap;
  endtask

  task automatic setlim(input logic [7:0] v);
    lim_we = 1;
    lim_din = v;
    @(negedge clk);
    lim_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic t;
    logic [15:0] d0, d1;
    int r0, w0;
    for (int i = 0; i < 256; i++) mem[i] = 16'hF000 | 16'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sp", sp_out, 0);
    chk("R1 trap", trap, 0);
    chk("R1 stall", stall, 0);
    chk("R1 mem_req", mem_req, 0);

    setlim(200);
    adjust(6, t);
    chk("R3 grow sp", sp_out, 6);
    chk("R12 no trap under new limit", t, 0);
    for (int a = 0; a < 6; a++) wr_a(a, 16'h100 + 16'(a));
    for (int k = 0; k < 6; k++) begin
      acc(1, 0, 4'(k), 1, 0, 4'((k + 1) % 6), 0, 0, 0, 0, d0, d1);
      chk("R2 port A", d0, expv[5 - k]);
      chk("R2 port B", d1, expv[5 - ((k + 1) % 6)]);
    end
    chk("R3 no fill reads", nrd, 0);
    chk("R3 no writes", nwr, 0);

    acc(1, 0, 2, 1, 0, 0, 1, 0, 2, 16'hBEEF, d0, d1);
    expv[3] = 16'hBEEF;
    chk("R8 stack bypass", d0, 16'hBEEF);
    chk("R8 other port", d1, expv[5]);
    acc(1, 1, 1, 0, 0, 0, 1, 1, 1, 16'h5A5A, d0, d1);
    chk("R8 global bypass", d0, 16'h5A5A);
    for (int g = 0; g < 4; g++) acc(0, 0, 0, 0, 0, 0, 1, 1, 4'(g), 16'h7000 + 16'(g), d0, d1);
    rd_a("R8 stored write", 3);

    adjust(0, t);
    chk("R10 zero delta trap", t, 0);
    chk("R10 zero delta sp", sp_out, 6);
    repeat (5) @(negedge clk);
    for (int a = 0; a < 6; a++) rd_a("R10 words kept", a);
    chk("R10 no traffic", nrd + nwr, 0);

    adjust(-3, t);
    chk("R4 shrink sp", sp_out, 3);
    chk("R4 no write-back", nwr, 0);
    adjust(3, t);
    chk("R3 regrow sp", sp_out, 6);
    chk("R3 regrow no read", nrd, 0);
    for (int a = 0; a < 6; a++) wr_a(a, 16'(a * 3 + 7));
    for (int g = 0; g < 4; g++) begin
      acc(1, 1, 4'(g), 1, 1, 4'(3 - g), 0, 0, 0, 0, d0, d1);
      chk("R6 global A", d0, 16'h7000 + 16'(g));
      chk("R6 global B", d1, 16'h7000 + 16'(3 - g));
    end

    setlim(20);
    adjust(15, t);
    chk("R5 over limit trap", t, 1);
    chk("R5 over limit sp", sp_out, 6);
    adjust(14, t);
    chk("R5 at limit no trap", t, 0);
    chk("R5 at limit sp", sp_out, 20);
    adjust(-14, t);
    chk("R4 shrink back", sp_out, 6);
    adjust(-7, t);
    chk("R5 underflow trap", t, 1);
    chk("R5 underflow sp", sp_out, 6);
    chk("R4 no traffic", nrd + nwr, 0);
    for (int a = 0; a < 6; a++) rd_a("R4 older words kept", a);
    setlim(200);

    adjust(8, t);
    chk("R11 grow sp", sp_out, 14);
    rd_a("R11 dirty older word readable", 1);
    chk("R11 no traffic yet", nrd + nwr, 0);
    wr_a(8, 16'hA008);
    chk("R11 one write-back", nwr, 1);
    chk("R11 no fill", nrd, 0);
    chk("R11 spilled value", mem[0], 7);
    for (int a = 9; a < 14; a++) wr_a(a, 16'hA000 + 16'(a));
    wr_a(6, 16'hA006);
    wr_a(7, 16'hA007);
    chk("R11 six write-backs", nwr, 6);
    chk("R11 still no fill", nrd, 0);
    for (int a = 0; a < 6; a++) chk("R11 memory holds older", mem[a], 16'(a * 3 + 7));

    rd_a("R7 miss returns memory word", 0);
    chk("R7 spill count", nwr, 7);
    chk("R7 fill count", nrd, 1);
    chk("R7 spilled new word", mem[8], 16'hA008);

    acc_valid = 1; rda_en = 1; rda_glob = 0; rda_off = 12;
    adj_valid = 1; adj_delta = 8'd1;
    #1;
    chk("R9 stall seen", stall, 1);
    while (stall) begin
      chk("R9 sp held", sp_out, 14);
      @(negedge clk);
      #1;
    end
    d0 = rda_data;
    @(negedge clk);
    acc_valid = 0; rda_en = 0; adj_valid = 0;
    chk("R9 access used old sp", d0, expv[1]);
    chk("R9 adjust applied after", sp_out, 15);
    chk("R7 second miss traffic", nrd + nwr, 10);
    rd_a("R7 hit after misses", 13);

    r0 = nrd;
    w0 = nwr;
    adjust(-15, t);
    chk("R4 drop all", sp_out, 0);
    for (int n = 1; n <= 8; n++) begin
      adjust(n, t);
      chk("R3 sweep sp", sp_out, 8'(n));
      for (int a = 0; a < n; a++) wr_a(a, 16'(n * 16 + a));
      for (int k = 0; k < n; k++) begin
        acc(1, 0, 4'(k), 1, 0, 4'(n - 1 - k), 0, 0, 0, 0, d0, d1);
        chk("R2 sweep A", d0, 16'(n * 16 + (n - 1 - k)));
        chk("R2 sweep B", d1, 16'(n * 16 + k));
      end
      adjust(-n, t);
      chk("R4 sweep shrink", sp_out, 0);
    end
    chk("R3 sweep no reads", nrd, r0);
    chk("R4 sweep no writes", nwr, w0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule